// File: doc/BRIEF.md
# Inverted Frame Table Translator

This block turns a (process id, virtual page number) key into a physical address by searching a single system-wide table that holds one word per physical frame. Each frame word names the process that owns the frame and the virtual page stored there. Since the table is ordered by frame and not by page, the key is first folded into a small hash. That hash selects a slot in an anchor table, and the slot holds the first frame of a chain of candidates. The block follows the chain one word at a time until it finds a word whose process id and page number both equal the key. The position of that word in the table is the frame number.

Both tables sit in one external memory that the block reads through a single registered read port. Each read delivers its data one cycle after it is issued. A lookup therefore takes a variable number of cycles, set by how far along its chain the key sits. The response reports one of three outcomes: a hit with the physical address, a fault when the key is absent, or an error when the walk runs past its step bound.

Top module: `ipt_lookup`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1 and `rsp_valid`, `mem_rd_en`, `rsp_hit`, `rsp_fault` and `rsp_error` are all 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. In the next cycle the block holds `req_ready` at 0 and issues one read at address {1'b0, hash}. The hash is the XOR of all HASH_W-bit slices of {pid, vpn}, taken from bit 0 upward, with the top slice padded with zeros.
- R3: An anchor word whose low FRAME_W bits are all ones marks an empty chain. The lookup then answers with a fault and issues no frame read. The other anchor bits are ignored.
- R4: A frame entry is read at address {1'b0 + 1, frame}, that is, with the top address bit set. The entry word is {valid, pid, vpn, next} with `next` in the low FRAME_W bits. The walk starts at the anchor's frame and follows `next`. Reads are single-cycle pulses.
- R5: An entry hits when its valid bit is 1 and both its pid and vpn fields equal the key. `rsp_paddr` is then {frame index of that entry, request offset}.
- R6: An entry with the same vpn but a different pid does not hit, and the walk continues along its link.
- R7: An entry with valid 0 never hits, even when its key fields match, but its link is still followed.
- R8: An entry that does not hit and whose `next` is all ones ends the walk with a fault. Frame index 2^FRAME_W-1 therefore cannot be reached through a link.
- R9: A walk reads at most 2^FRAME_W entries. If the last of those does not hit and does not end the chain, the response is an error.
- R10: With k entry reads, `rsp_valid` rises 2+2k cycles after the accepting edge and lasts one cycle. On that cycle exactly one of hit, fault and error is 1, and all three are 0 on every other cycle.
- R11: Requests presented while a lookup is in flight are ignored. They cause no read and no extra response, and they do not change the result of the lookup in flight. `req_ready` returns to 1 in the same cycle as the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_pid | input | PID_W | Process id of the key |
| req_vpn | input | VPN_W | Virtual page number of the key |
| req_off | input | OFF_W | Page offset carried into the address |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_addr | output | FRAME_W+1 | Table read address (top bit selects frame entries) |
| mem_rd_data | input | 1+PID_W+VPN_W+FRAME_W | Read data, valid one cycle after the strobe |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Key found |
| rsp_fault | output | 1 | Key absent |
| rsp_error | output | 1 | Step bound exceeded |
| rsp_paddr | output | FRAME_W+OFF_W | Frame index and offset on a hit |

## Verification
The bench builds chains in which the matching key sits behind entries that nearly match. One decoy has the right page number under another process; a design that ignored the process id would return that decoy's frame. Another decoy is an invalid entry whose key fields match; a design that did not gate on the valid bit would hit on it, and one that stopped at invalid entries would report a fault where a hit lies further on. A chain linked back to itself must end in an error after exactly the bounded number of reads, so an off-by-one in the bound shows up as a wrong latency or a hang. Random tables compared against a chain-walk model check the latency against the read count and the offset pass-through, and requests sent while the block is busy must leave the result of the lookup in flight unchanged.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_ANC_REQ,
    WS_ANC_USE,
    WS_ENT_REQ,
    WS_ENT_USE
  } walk_state_t;

endpackage

// File: rtl/ipt_key_hash.sv
module ipt_key_hash #(
  parameter int KEY_W  = 12,
  parameter int HASH_W = 3
) (
  input  logic [KEY_W-1:0]  key,
  output logic [HASH_W-1:0] idx
);

  localparam int NSL   = (KEY_W + HASH_W - 1) / HASH_W;
  localparam int PAD_W = NSL * HASH_W;

  logic [PAD_W-1:0]  padded;
  logic [HASH_W-1:0] acc [NSL+1];

  assign padded = PAD_W'(key);
  assign acc[0] = '0;

  for (genvar g = 0; g < NSL; g++) begin : g_fold
    assign acc[g+1] = acc[g] ^ padded[g*HASH_W +: HASH_W];
  end

  assign idx = acc[NSL];

endmodule

// File: rtl/ipt_entry_decode.sv
module ipt_entry_decode #(
  parameter int PID_W   = 4,
  parameter int VPN_W   = 8,
  parameter int FRAME_W = 4
) (
  input  logic [PID_W+VPN_W+FRAME_W:0] word,
  input  logic [PID_W-1:0]             key_pid,
  input  logic [VPN_W-1:0]             key_vpn,
  output logic [FRAME_W-1:0]           link,
  output logic                         link_end,
  output logic                         key_hit
);

  localparam int VPN_LSB = FRAME_W;
  localparam int PID_LSB = FRAME_W + VPN_W;
  localparam int VLD_BIT = FRAME_W + VPN_W + PID_W;

  logic             ent_valid;
  logic [PID_W-1:0] ent_pid;
  logic [VPN_W-1:0] ent_vpn;

  always_comb begin
    link      = word[FRAME_W-1:0];
    ent_vpn   = word[VPN_LSB +: VPN_W];
    ent_pid   = word[PID_LSB +: PID_W];
    ent_valid = word[VLD_BIT];
    link_end  = &link;
    key_hit   = ent_valid && (ent_pid == key_pid) && (ent_vpn == key_vpn);
  end

endmodule

// File: rtl/ipt_walk_ctrl.sv
module ipt_walk_ctrl
  import ipt_pkg::*;
#(
  parameter int FRAME_W = 4,
  parameter int HASH_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [HASH_W-1:0]  anchor_idx,
  input  logic [FRAME_W-1:0] link,
  input  logic               link_end,
  input  logic               key_hit,
  output logic               ready,
  output logic               mem_rd_en,
  output logic [FRAME_W:0]   mem_rd_addr,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_fault,
  output logic               rsp_error,
  output logic [FRAME_W-1:0] rsp_frame
);

  localparam int               FRAMES = 1 << FRAME_W;
  localparam int               CNT_W  = FRAME_W + 1;
  localparam logic [CNT_W-1:0] LIMIT  = CNT_W'(FRAMES);

  walk_state_t        state;
  logic [FRAME_W-1:0] cur_q;
  logic [CNT_W-1:0]   steps_q;

  assign ready = (state == WS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= WS_IDLE;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_error   <= 1'b0;
      rsp_frame   <= '0;
      cur_q       <= '0;
      steps_q     <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_error <= 1'b0;
      unique case (state)
        WS_IDLE: begin
          if (start) begin
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= {1'b0, FRAME_W'(anchor_idx)};
            state       <= WS_ANC_REQ;
          end
        end
        WS_ANC_REQ: state <= WS_ANC_USE;
        WS_ANC_USE: begin
          if (link_end) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
            state     <= WS_IDLE;
          end else begin
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= {1'b1, link};
            cur_q       <= link;
            steps_q     <= CNT_W'(1);
            state       <= WS_ENT_REQ;
          end
        end
        WS_ENT_REQ: state <= WS_ENT_USE;
        WS_ENT_USE: begin
          if (key_hit) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b1;
            rsp_frame <= cur_q;
            state     <= WS_IDLE;
          end else if (link_end) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
            state     <= WS_IDLE;
          end else if (steps_q == LIMIT) begin
            rsp_valid <= 1'b1;
            rsp_error <= 1'b1;
            state     <= WS_IDLE;
          end else begin
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= {1'b1, link};
            cur_q       <= link;
            steps_q     <= steps_q + CNT_W'(1);
            state       <= WS_ENT_REQ;
          end
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
  parameter int PID_W   = 4,
  parameter int VPN_W   = 8,
  parameter int OFF_W   = 6,
  parameter int FRAME_W = 4,
  parameter int HASH_W  = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [PID_W-1:0]             req_pid,
  input  logic [VPN_W-1:0]             req_vpn,
  input  logic [OFF_W-1:0]             req_off,
  output logic                         mem_rd_en,
  output logic [FRAME_W:0]             mem_rd_addr,
  input  logic [PID_W+VPN_W+FRAME_W:0] mem_rd_data,
  output logic                         rsp_valid,
  output logic                         rsp_hit,
  output logic                         rsp_fault,
  output logic                         rsp_error,
  output logic [FRAME_W+OFF_W-1:0]     rsp_paddr
);

  localparam int KEY_W = PID_W + VPN_W;

  logic               start;
  logic [HASH_W-1:0]  anchor_idx;
  logic [PID_W-1:0]   pid_q;
  logic [VPN_W-1:0]   vpn_q;
  logic [OFF_W-1:0]   off_q;
  logic [FRAME_W-1:0] link;
  logic               link_end;
  logic               key_hit;
  logic [FRAME_W-1:0] rsp_frame;

  assign start = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pid_q <= '0;
      vpn_q <= '0;
      off_q <= '0;
    end else if (start) begin
      pid_q <= req_pid;
      vpn_q <= req_vpn;
      off_q <= req_off;
    end
  end

  ipt_key_hash #(
    .KEY_W (KEY_W),
    .HASH_W(HASH_W)
  ) u_hash (
    .key({req_pid, req_vpn}),
    .idx(anchor_idx)
  );

  ipt_entry_decode #(
    .PID_W  (PID_W),
    .VPN_W  (VPN_W),
    .FRAME_W(FRAME_W)
  ) u_decode (
    .word    (mem_rd_data),
    .key_pid (pid_q),
    .key_vpn (vpn_q),
    .link    (link),
    .link_end(link_end),
    .key_hit (key_hit)
  );

  ipt_walk_ctrl #(
    .FRAME_W(FRAME_W),
    .HASH_W (HASH_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .anchor_idx (anchor_idx),
    .link       (link),
    .link_end   (link_end),
    .key_hit    (key_hit),
    .ready      (req_ready),
    .mem_rd_en  (mem_rd_en),
    .mem_rd_addr(mem_rd_addr),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_fault  (rsp_fault),
    .rsp_error  (rsp_error),
    .rsp_frame  (rsp_frame)
  );

  assign rsp_paddr = {rsp_frame, off_q};

endmodule

// File: rtl/ipt_lookup_chk.sv
module ipt_lookup_chk #(
  parameter int FRAME_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             mem_rd_en,
  input logic [FRAME_W:0] mem_rd_addr,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_fault,
  input logic             rsp_error
);

  localparam int FRAMES = 1 << FRAME_W;
  localparam int CW     = FRAME_W + 2;

  logic [CW-1:0] frame_reads;

  always_ff @(posedge clk) begin
    if (rst) frame_reads <= '0;
    else if (req_valid && req_ready) frame_reads <= '0;
    else if (mem_rd_en && mem_rd_addr[FRAME_W]) frame_reads <= frame_reads + CW'(1);
  end

  AST_ACCEPT_ANCHOR_RD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (mem_rd_en && !mem_rd_addr[FRAME_W] && !req_ready)); // R2

  AST_READ_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en); // R4

  AST_WALK_BOUND: assert property (@(posedge clk) disable iff (rst)
    frame_reads <= CW'(FRAMES)); // R9

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({rsp_hit, rsp_fault, rsp_error}) == 1)); // R10

  AST_QUIET_FLAGS: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_fault || rsp_error)); // R10

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R10

  AST_RSP_READY: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready); // R11

endmodule

bind ipt_lookup ipt_lookup_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .mem_rd_en  (mem_rd_en),
  .mem_rd_addr(mem_rd_addr),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_fault  (rsp_fault),
  .rsp_error  (rsp_error)
);

// File: tb/ipt_lookup_tb.sv
module ipt_lookup_tb;

  localparam int PW = 4;
  localparam int VW = 8;
  localparam int OW = 6;
  localparam int FW = 4;
  localparam int HW = 3;
  localparam int EW = 1 + PW + VW + FW;
  localparam int FR = 1 << FW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [PW-1:0] req_pid = '0;
  logic [VW-1:0] req_vpn = '0;
  logic [OW-1:0] req_off = '0;
  logic          mem_rd_en;
  logic [FW:0]   mem_rd_addr;
  logic [EW-1:0] mem_rd_data = '0;
  logic          rsp_valid, rsp_hit, rsp_fault, rsp_error;
  logic [FW+OW-1:0] rsp_paddr;

  logic [EW-1:0] tbl [2*FR];

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  ipt_lookup #(.PID_W(PW), .VPN_W(VW), .OFF_W(OW), .FRAME_W(FW), .HASH_W(HW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_pid(req_pid), .req_vpn(req_vpn), .req_off(req_off),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_error(rsp_error), .rsp_paddr(rsp_paddr)
  );

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= tbl[mem_rd_addr];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [HW-1:0] hsh(input logic [PW-1:0] p, input logic [VW-1:0] v);
    logic [PW+VW-1:0] k = {p, v};
    logic [HW-1:0] h = '0;
    for (int i = 0; i < (PW + VW) / HW; i++) h ^= k[i*HW +: HW];
    return h;
  endfunction

  function automatic logic [EW-1:0] mk(input bit vld, input logic [PW-1:0] p,
                                       input logic [VW-1:0] v, input logic [FW-1:0] nx);
    return {vld, p, v, nx};
  endfunction

  function automatic logic [EW-1:0] anc(input logic [FW-1:0] f);
    return {{(EW-FW){1'b1}}, f};
  endfunction

  task automatic clear_tbl();
    for (int i = 0; i < FR; i++) tbl[i] = '1;
    for (int i = 0; i < FR; i++) tbl[FR+i] = mk(1'b0, '0, '0, '1);
  endtask

  // outcome code: 0 hit, 1 fault, 2 error
  task automatic model(input logic [PW-1:0] p, input logic [VW-1:0] v,
                       output int oc, output logic [FW-1:0] fr, output int k);
    logic [FW-1:0] cur = tbl[hsh(p, v)][FW-1:0];
    logic [EW-1:0] w;
    k = 0; fr = '0; oc = 1;
    if (&cur) return;
    forever begin
      if (k == FR) begin oc = 2; return; end
      w = tbl[FR + int'(cur)];
      k++;
      if (w[EW-1] && w[FW+VW +: PW] == p && w[FW +: VW] == v) begin oc = 0; fr = cur; return; end
      if (&w[FW-1:0]) begin oc = 1; return; end
      cur = w[FW-1:0];
    end
  endtask

  task automatic lookup(input logic [PW-1:0] p, input logic [VW-1:0] v,
                        input logic [OW-1:0] o, input bit noise, input string tag);
    int oc, k, n, reads, aoc;
    logic [FW-1:0] fr;
    model(p, v, oc, fr, k);
    @(negedge clk);
    chk(req_ready, "R11 ready before request", 32'(req_ready), 1);
    req_valid = 1'b1; req_pid = p; req_vpn = v; req_off = o;
    @(negedge clk);
    chk(mem_rd_en && mem_rd_addr == {1'b0, FW'(hsh(p, v))} && !req_ready,
        "R2 anchor read", 32'({mem_rd_en, req_ready, mem_rd_addr}),
        32'({2'b10, 1'b0, FW'(hsh(p, v))}));
    if (noise) begin
      req_pid = ~p; req_vpn = v ^ 8'h5A; req_off = ~o;
    end else req_valid = 1'b0;
    n = 0; reads = 0;
    while (!rsp_valid && n < 80) begin
      @(negedge clk);
      n++;
      if (mem_rd_en && mem_rd_addr[FW]) reads++;
    end
    req_valid = 1'b0;
    aoc = rsp_hit ? 0 : rsp_fault ? 1 : rsp_error ? 2 : 3;
    chk(aoc == oc, {tag, " outcome"}, 32'(aoc), 32'(oc));
    chk(n == 2 + 2 * k, "R10 latency", 32'(n), 32'(2 + 2 * k));
    chk(reads == k, "R4 entry reads", 32'(reads), 32'(k));
    if (oc == 0) chk(rsp_paddr == {fr, o}, {tag, " paddr"}, 32'(rsp_paddr), 32'({fr, o}));
    @(negedge clk);
    chk(!rsp_valid && req_ready && !mem_rd_en, "R10 R11 pulse and idle",
        32'({rsp_valid, req_ready, mem_rd_en}), 32'(3'b010));
  endtask

  task automatic rand_tbl();
    logic [PW-1:0] p;
    logic [VW-1:0] v;
    logic [HW-1:0] h;
    clear_tbl();
    for (int f = 0; f < FR - 1; f++) begin
      p = PW'($urandom); v = VW'($urandom);
      h = hsh(p, v);
      tbl[FR+f] = mk(($urandom % 8) != 0, p, v, tbl[h][FW-1:0]);
      tbl[h] = anc(FW'(f));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [EW-1:0] w;
    int f;
    void'($urandom(32'd2024));
    clear_tbl();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    chk(req_ready && !rsp_valid && !mem_rd_en && !rsp_hit && !rsp_fault && !rsp_error,
        "R1 reset state", 32'({req_ready, rsp_valid, mem_rd_en, rsp_hit, rsp_fault, rsp_error}),
        32'(6'b100000));

    // R3: empty anchor gives a fault after two cycles
    lookup(4'h3, 8'h21, 6'h05, 1'b0, "R3");

    // R6: same vpn under another pid sits ahead of the real entry
    clear_tbl();
    tbl[hsh(4'h1, 8'h3C)] = anc(4'd5);
    tbl[FR+5] = mk(1'b1, 4'h2, 8'h3C, 4'd9);
    tbl[FR+9] = mk(1'b1, 4'h1, 8'h3C, 4'hF);
    lookup(4'h1, 8'h3C, 6'h11, 1'b0, "R6");

    // R7: invalid entry with matching key is skipped, link followed
    clear_tbl();
    tbl[hsh(4'h6, 8'h81)] = anc(4'd2);
    tbl[FR+2] = mk(1'b0, 4'h6, 8'h81, 4'd7);
    tbl[FR+7] = mk(1'b1, 4'h6, 8'h81, 4'hF);
    lookup(4'h6, 8'h81, 6'h2A, 1'b0, "R7");

    // R8: chain of non-matching entries ends in a fault
    clear_tbl();
    tbl[hsh(4'h9, 8'h44)] = anc(4'd0);
    tbl[FR+0] = mk(1'b1, 4'h9, 8'h45, 4'd1);
    tbl[FR+1] = mk(1'b1, 4'h8, 8'h44, 4'd4);
    tbl[FR+4] = mk(1'b1, 4'h1, 8'h00, 4'hF);
    lookup(4'h9, 8'h44, 6'h00, 1'b0, "R8");

    // R9: self-linked entry yields an error after the step bound
    clear_tbl();
    tbl[hsh(4'h7, 8'h11)] = anc(4'd3);
    tbl[FR+3] = mk(1'b1, 4'h0, 8'h00, 4'd3);
    lookup(4'h7, 8'h11, 6'h01, 1'b0, "R9");

    // R5: highest usable frame with full offset
    clear_tbl();
    tbl[hsh(4'hF, 8'hFF)] = anc(4'd14);
    tbl[FR+14] = mk(1'b1, 4'hF, 8'hFF, 4'hF);
    lookup(4'hF, 8'hFF, 6'h3F, 1'b0, "R5");

    // R11: other requests held while busy are ignored
    lookup(4'hF, 8'hFF, 6'h15, 1'b1, "R11");

    // R5 random tables against the chain model
    for (int r = 0; r < 6; r++) begin
      rand_tbl();
      for (int i = 0; i < 40; i++) begin
        if ($urandom % 2) begin
          f = int'($urandom % (FR - 1));
          w = tbl[FR+f];
          lookup(w[FW+VW +: PW], w[FW +: VW], OW'($urandom), (i % 7) == 0, "R5");
        end else begin
          lookup(PW'($urandom), VW'($urandom), OW'($urandom), 1'b0, "R8");
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule